// File: doc/BRIEF.md
# Channel Attention Control Decoder

The decoder sits between a shared control block in memory and two execution engines: a command unit, which walks a linked list of commands, and a receive unit, which fills frame buffers. Each time the host raises a channel attention request, the block takes the current 16-bit control command word. It acknowledges event bits, moves either unit to a new state, and may apply a soft reset. It then presents a fresh 16-bit status word for write-back, asks for the command word in memory to be cleared, and starts the command loop. If the command list pointer is null and the command unit may run, it also asks for the pointer to be reloaded from the list head.

Each decode takes three cycles: an idle cycle that accepts the request, a decode cycle, and a write-back cycle. Attention requests that arrive while a decode is under way are counted in a small saturating counter and served one after another. Event inputs from the command loop and the receive path set sticky bits in the status word. Software clears these bits by writing ones in the matching positions of a later command word.

Top module: `ca_ctl_decoder`

## Requirements
- R1: After reset the command unit state is idle (0), the receive unit state is suspended (1), the status word reads 0x0010, the command list pointer counts as null, and every strobe output is low.
- R2: The status word holds the event bits in 15:12, the command unit state in 9:8 and the receive unit state in 6:4. All other bits are zero. The state encodings are: command unit idle 0, suspended 1, active 2; receive unit idle 0, suspended 1, ready 4.
- R3: The event bits are 15 (command done with interrupt), 14 (frame received), 13 (command unit left active) and 12 (receive unit left active). A pulse on cx_event sets bit 15 and a pulse on fr_event sets bit 14. A pulse in the decode cycle wins over an acknowledge or soft reset in that same cycle.
- R4: Bits 15:12 of the command word clear the event bits that are set in the same positions.
- R5: The command unit opcode is in command bits 10:8. Value 0 leaves the state as it is, 1 makes it active (2), and 4 makes it suspended (1) and sets event bit 13.
- R6: The receive unit opcode is in command bits 6:4. Values 1 and 2 make it idle (0). Values 3 and 4 make it suspended (1) and set event bit 12. Value 0 leaves the state as it is.
- R7: An unknown opcode leaves its own unit unchanged. Unknown command unit opcodes are 2, 3, 5, 6 and 7; unknown receive unit opcodes are 5, 6 and 7. An unknown opcode raises op_error for the single write-back cycle.
- R8: Command bit 7 applies a soft reset after the opcodes. It makes the command unit idle and the receive unit suspended, clears all event bits and makes the pointer null. A pulse on sw_reset does the same at any time and also drops any pending attention requests and any decode in progress.
- R9: An attention request seen while idle gives cmd_clear in the next cycle, when scb_cmd is sampled. In the cycle after that, status_we and loop_start pulse together and the status word already shows the new state.
- R10: In the write-back cycle, fetch_ptr is asserted when the command unit is not suspended and the pointer is null, after which the pointer counts as loaded. A pulse on list_done makes the pointer null again.
- R11: Attention requests that arrive while a decode is busy are counted, saturating at 2^PEND_W-1. Each counted request is later served by its own full decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| attn | input | 1 | Channel attention request pulse |
| scb_cmd | input | 16 | Current control command word from shared memory |
| sw_reset | input | 1 | Software reset pulse |
| cx_event | input | 1 | Command completed with interrupt flag |
| fr_event | input | 1 | Frame received |
| list_done | input | 1 | Command loop reached the end of its list; pointer becomes null |
| cu_state | output | 2 | Command unit state |
| ru_state | output | 3 | Receive unit state |
| status_word | output | 16 | Composed status word |
| status_we | output | 1 | Write-back strobe for the status word |
| cmd_clear | output | 1 | Request to zero the command word in memory |
| fetch_ptr | output | 1 | Request to load the command pointer from the list head |
| loop_start | output | 1 | Start pulse for the command loop |
| op_error | output | 1 | Unknown opcode seen in this decode |

## Verification
Some behaviours are checked by assertions on every cycle. The unit states never take an illegal encoding. A "left active" event bit only rises right after a decode cycle. Write-back always follows a clear request, and the error flag never lasts two cycles. Event pulses stay latched, and the pending count grows while the decoder is busy. The rest can only be shown by the bench's scenarios: the exact status value after each of the 4096 combinations of acknowledge, opcode and reset bits, the pointer fetch decision, and the number of decodes a burst of requests produces, including saturation and a flush by software reset.

// File: rtl/ca_pkg.sv
package ca_pkg;

    localparam int CMD_W = 16;
    localparam int EV_W  = 4;

    // event vector index (bit 3 maps to status bit 15)
    localparam int EV_CX  = 3;
    localparam int EV_FR  = 2;
    localparam int EV_CNA = 1;
    localparam int EV_RNR = 0;

    typedef enum logic [1:0] {
        CU_IDLE = 2'd0,
        CU_SUSP = 2'd1,
        CU_ACT  = 2'd2
    } cu_state_e;

    typedef enum logic [2:0] {
        RU_IDLE  = 3'd0,
        RU_SUSP  = 3'd1,
        RU_READY = 3'd4
    } ru_state_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_DEC  = 2'd1,
        SEQ_POST = 2'd2
    } seq_e;

    typedef struct packed {
        logic [EV_W-1:0] ack;
        logic            rsv_hi;
        logic [2:0]      cu_op;
        logic            srst;
        logic [2:0]      ru_op;
        logic [3:0]      rsv_lo;
    } cmd_fields_t;

    typedef struct packed {
        logic      cu_chg;
        cu_state_e cu_nxt;
        logic      ru_chg;
        ru_state_e ru_nxt;
        logic      set_cna;
        logic      set_rnr;
        logic      bad;
    } decode_t;

    function automatic cmd_fields_t split_cmd(input logic [CMD_W-1:0] w);
        return cmd_fields_t'(w);
    endfunction

    function automatic logic [CMD_W-1:0] compose_status(
        input logic [EV_W-1:0] ev,
        input cu_state_e       cu,
        input ru_state_e       ru
    );
        return {ev, 2'b00, cu, 1'b0, ru, 4'b0000};
    endfunction

endpackage

// File: rtl/ca_unit_decode.sv
module ca_unit_decode
    import ca_pkg::*;
(
    input  cmd_fields_t f,
    output decode_t     d
);
    logic unused_rsv;
    assign unused_rsv = ^{f.rsv_hi, f.rsv_lo, f.srst, f.ack};

    logic cu_bad;
    logic ru_bad;

    always_comb begin
        d        = '0;
        d.cu_nxt = CU_IDLE;
        d.ru_nxt = RU_IDLE;
        cu_bad   = 1'b0;
        ru_bad   = 1'b0;

        case (f.cu_op)
            3'd0: ;
            3'd1: begin
                d.cu_chg = 1'b1;
                d.cu_nxt = CU_ACT;
            end
            3'd4: begin
                d.cu_chg  = 1'b1;
                d.cu_nxt  = CU_SUSP;
                d.set_cna = 1'b1;
            end
            default: cu_bad = 1'b1;
        endcase

        case (f.ru_op)
            3'd0: ;
            3'd1, 3'd2: begin
                d.ru_chg = 1'b1;
                d.ru_nxt = RU_IDLE;
            end
            3'd3, 3'd4: begin
                d.ru_chg  = 1'b1;
                d.ru_nxt  = RU_SUSP;
                d.set_rnr = 1'b1;
            end
            default: ru_bad = 1'b1;
        endcase

        d.bad = cu_bad | ru_bad;
    end

endmodule

// File: rtl/ca_status_events.sv
module ca_status_events
    import ca_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            ack_en,
    input  logic [EV_W-1:0] ack_mask,
    input  logic            set_cna,
    input  logic            set_rnr,
    input  logic            soft_clr,
    input  logic            cx_evt,
    input  logic            fr_evt,
    output logic [EV_W-1:0] ev
);
    logic [EV_W-1:0] ev_nxt;

    always_comb begin
        ev_nxt = ev;
        if (ack_en) begin
            ev_nxt = ev_nxt & ~ack_mask;
        end
        ev_nxt[EV_CNA] = ev_nxt[EV_CNA] | set_cna;
        ev_nxt[EV_RNR] = ev_nxt[EV_RNR] | set_rnr;
        if (soft_clr) begin
            ev_nxt = '0;
        end
        // external events win over acknowledge and soft clear
        ev_nxt[EV_CX] = ev_nxt[EV_CX] | cx_evt;
        ev_nxt[EV_FR] = ev_nxt[EV_FR] | fr_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ev <= '0;
        end else begin
            ev <= ev_nxt;
        end
    end

    // R3: an event pulse is visible in the next cycle
    a_r3_cx_sticks: assert property (@(posedge clk) disable iff (rst)
        cx_evt |=> ev[EV_CX]);
    a_r3_fr_sticks: assert property (@(posedge clk) disable iff (rst)
        fr_evt |=> ev[EV_FR]);

endmodule

// File: rtl/ca_attn_seq.sv
module ca_attn_seq
    import ca_pkg::*;
#(
    parameter int PEND_W = 2
)(
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic attn,
    output logic in_dec,
    output logic in_post
);
    localparam logic [PEND_W-1:0] PEND_MAX  = {PEND_W{1'b1}};
    localparam logic [PEND_W-1:0] PEND_ZERO = '0;
    localparam logic [PEND_W-1:0] PEND_ONE  = PEND_W'(1);

    seq_e              st;
    logic [PEND_W-1:0] pend;
    logic              start;

    assign start   = (st == SEQ_IDLE) && (attn || (pend != PEND_ZERO));
    assign in_dec  = (st == SEQ_DEC);
    assign in_post = (st == SEQ_POST);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            st   <= SEQ_IDLE;
            pend <= PEND_ZERO;
        end else begin
            case (st)
                SEQ_IDLE: if (start) st <= SEQ_DEC;
                SEQ_DEC:  st <= SEQ_POST;
                default:  st <= SEQ_IDLE;
            endcase

            if (st != SEQ_IDLE) begin
                if (attn && (pend != PEND_MAX)) begin
                    pend <= pend + PEND_ONE;
                end
            end else if (start && !attn && (pend != PEND_ZERO)) begin
                pend <= pend - PEND_ONE;
            end
        end
    end

    // R11: a busy-time request is counted
    a_r11_busy_counts: assert property (@(posedge clk) disable iff (rst || flush)
        (attn && (st != SEQ_IDLE) && (pend != PEND_MAX)) |=> (pend == $past(pend) + PEND_ONE));

    // R9: decode cycle is followed by write-back cycle
    a_r9_dec_to_post: assert property (@(posedge clk) disable iff (rst || flush)
        in_dec |=> in_post);

endmodule

// File: rtl/ca_ctl_decoder.sv
module ca_ctl_decoder
    import ca_pkg::*;
#(
    parameter int PEND_W = 2
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        attn,
    input  logic [15:0] scb_cmd,
    input  logic        sw_reset,
    input  logic        cx_event,
    input  logic        fr_event,
    input  logic        list_done,
    output logic [1:0]  cu_state,
    output logic [2:0]  ru_state,
    output logic [15:0] status_word,
    output logic        status_we,
    output logic        cmd_clear,
    output logic        fetch_ptr,
    output logic        loop_start,
    output logic        op_error
);
    logic        in_dec;
    logic        in_post;
    cmd_fields_t fld;
    decode_t     dec;
    logic [EV_W-1:0] ev;

    cu_state_e cu_q;
    ru_state_e ru_q;
    logic      ptr_null_q;
    logic      err_q;

    assign fld = split_cmd(scb_cmd);

    ca_attn_seq #(.PEND_W(PEND_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .flush   (sw_reset),
        .attn    (attn),
        .in_dec  (in_dec),
        .in_post (in_post)
    );

    ca_unit_decode u_dec (
        .f (fld),
        .d (dec)
    );

    ca_status_events u_ev (
        .clk      (clk),
        .rst      (rst),
        .ack_en   (in_dec),
        .ack_mask (fld.ack),
        .set_cna  (in_dec & dec.set_cna),
        .set_rnr  (in_dec & dec.set_rnr),
        .soft_clr (sw_reset | (in_dec & fld.srst)),
        .cx_evt   (cx_event),
        .fr_evt   (fr_event),
        .ev       (ev)
    );

    always_ff @(posedge clk) begin
        if (rst || sw_reset) begin
            cu_q       <= CU_IDLE;
            ru_q       <= RU_SUSP;
            ptr_null_q <= 1'b1;
            err_q      <= 1'b0;
        end else begin
            if (in_dec) begin
                err_q <= dec.bad;
                if (fld.srst) begin
                    cu_q       <= CU_IDLE;
                    ru_q       <= RU_SUSP;
                    ptr_null_q <= 1'b1;
                end else begin
                    if (dec.cu_chg) cu_q <= dec.cu_nxt;
                    if (dec.ru_chg) ru_q <= dec.ru_nxt;
                end
            end
            if (fetch_ptr) begin
                ptr_null_q <= 1'b0;
            end
            if (list_done) begin
                ptr_null_q <= 1'b1;
            end
        end
    end

    assign cu_state    = cu_q;
    assign ru_state    = ru_q;
    assign status_word = compose_status(ev, cu_q, ru_q);
    assign cmd_clear   = in_dec;
    assign status_we   = in_post;
    assign loop_start  = in_post;
    assign op_error    = in_post & err_q;
    assign fetch_ptr   = in_post & (cu_q != CU_SUSP) & ptr_null_q;

    // R9: write-back follows the clear request
    a_r9_clear_then_we: assert property (@(posedge clk) disable iff (rst || sw_reset)
        cmd_clear |=> status_we);

    // R5: command unit left-active bit only rises out of a decode
    a_r5_cna_from_decode: assert property (@(posedge clk) disable iff (rst || sw_reset)
        $rose(status_word[13]) |-> $past(cmd_clear));

    // R6: receive unit left-active bit only rises out of a decode
    a_r6_rnr_from_decode: assert property (@(posedge clk) disable iff (rst || sw_reset)
        $rose(status_word[12]) |-> $past(cmd_clear));

    // R7: error flag lasts one cycle
    a_r7_err_single: assert property (@(posedge clk) disable iff (rst || sw_reset)
        op_error |=> !op_error);

    // R2: legal state encodings only
    a_r2_cu_legal: assert property (@(posedge clk) disable iff (rst)
        cu_state != 2'd3);
    a_r2_ru_legal: assert property (@(posedge clk) disable iff (rst)
        (ru_state == 3'd0) || (ru_state == 3'd1) || (ru_state == 3'd4));

endmodule

// File: tb/ca_ctl_decoder_bench.sv
module ca_ctl_decoder_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        attn;
    logic [15:0] scb_cmd;
    logic        sw_reset;
    logic        cx_event;
    logic        fr_event;
    logic        list_done;
    logic [1:0]  cu_state;
    logic [2:0]  ru_state;
    logic [15:0] status_word;
    logic        status_we;
    logic        cmd_clear;
    logic        fetch_ptr;
    logic        loop_start;
    logic        op_error;

    int n_chk  = 0;
    int n_fail = 0;
    int ls_total = 0;
    bit done = 1'b0;

    // model state
    int         mcu;
    int         mru;
    logic [3:0] mev;
    bit         mnull;
    logic [15:0] e_stat;
    bit          e_fetch;
    bit          e_err;

    always #(PERIOD/2) clk = ~clk;

    ca_ctl_decoder u_ca_ctl_decoder (
        .clk(clk), .rst(rst), .attn(attn), .scb_cmd(scb_cmd),
        .sw_reset(sw_reset), .cx_event(cx_event), .fr_event(fr_event),
        .list_done(list_done), .cu_state(cu_state), .ru_state(ru_state),
        .status_word(status_word), .status_we(status_we), .cmd_clear(cmd_clear),
        .fetch_ptr(fetch_ptr), .loop_start(loop_start), .op_error(op_error)
    );

    always @(negedge clk) if (loop_start) ls_total++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        mcu = 0; mru = 1; mev = 4'h0; mnull = 1'b1;
    endtask

    // expected effect of one decode, per R4..R8 and R10
    task automatic model_cmd(input logic [15:0] c);
        logic [3:0] ev;
        ev = mev & ~c[15:12];
        e_err = 1'b0;
        case (c[10:8])
            3'd0: ;
            3'd1: mcu = 2;
            3'd4: begin mcu = 1; ev[1] = 1'b1; end
            default: e_err = 1'b1;
        endcase
        case (c[6:4])
            3'd0: ;
            3'd1, 3'd2: mru = 0;
            3'd3, 3'd4: begin mru = 1; ev[0] = 1'b1; end
            default: e_err = 1'b1;
        endcase
        if (c[7]) begin
            mcu = 0; mru = 1; ev = 4'h0; mnull = 1'b1;
        end
        mev = ev;
        e_stat = {mev, 4'h0, 8'h0} | 16'(mcu << 8) | 16'(mru << 4);
        e_fetch = (mcu != 1) && mnull;
    endtask

    // starts and ends at a negedge with the decoder idle
    task automatic run_decode(input logic [15:0] c);
        model_cmd(c);
        attn = 1'b1; scb_cmd = c;
        @(negedge clk);
        attn = 1'b0;
        chk("R9 cmd_clear", 32'(cmd_clear), 32'd1);
        @(negedge clk);
        chk("R9 status_we", 32'(status_we), 32'd1);
        chk("R9 loop_start", 32'(loop_start), 32'd1);
        chk("R2 R4 R5 R6 R8 status", 32'(status_word), 32'(e_stat));
        chk("R5 cu_state", 32'(cu_state), 32'(mcu));
        chk("R6 ru_state", 32'(ru_state), 32'(mru));
        chk("R10 fetch_ptr", 32'(fetch_ptr), 32'(e_fetch));
        chk("R7 op_error", 32'(op_error), 32'(e_err));
        if (e_fetch) mnull = 1'b0;
        @(negedge clk);
        chk("R7 R9 strobes low", 32'({status_we, cmd_clear, op_error}), 32'd0);
    endtask

    task automatic pulse_inputs(input bit cx, input bit fr, input bit ld);
        cx_event = cx; fr_event = fr; list_done = ld;
        @(negedge clk);
        cx_event = 1'b0; fr_event = 1'b0; list_done = 1'b0;
        if (cx) mev[3] = 1'b1;
        if (fr) mev[2] = 1'b1;
        if (ld) mnull = 1'b1;
    endtask

    initial begin
        int base;
        rst = 1'b1; attn = 1'b0; scb_cmd = 16'h0; sw_reset = 1'b0;
        cx_event = 1'b0; fr_event = 1'b0; list_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();

        // R1: reset state
        chk("R1 cu_state", 32'(cu_state), 32'd0);
        chk("R1 ru_state", 32'(ru_state), 32'd1);
        chk("R1 status", 32'(status_word), 32'h0010);
        chk("R1 strobes", 32'({status_we, cmd_clear, fetch_ptr, loop_start, op_error}), 32'd0);

        // R1/R10: first no-op decode fetches the null pointer
        run_decode(16'h0000);

        // R3: events latch
        pulse_inputs(1'b1, 1'b1, 1'b0);
        chk("R3 event bits", 32'(status_word[15:14]), 32'd3);

        // R2..R8, R10: sweep every ack, opcode and reset combination
        for (int k = 0; k < 4096; k++) begin
            pulse_inputs((k % 3) == 0, (k % 5) == 1, (k % 7) == 2);
            run_decode(16'(k << 4));
        end

        // R3: event pulse in the decode cycle wins over its acknowledge
        model_cmd(16'h8080);
        attn = 1'b1; scb_cmd = 16'h8080;
        @(negedge clk);
        attn = 1'b0; cx_event = 1'b1;
        @(negedge clk);
        cx_event = 1'b0;
        chk("R3 R8 event survives ack and soft reset", 32'(status_word), 32'h8010);
        @(negedge clk);
        mev[3] = 1'b1; mnull = 1'b0;

        // R8: sw_reset pulse
        run_decode(16'h0100);
        chk("R5 active before sw reset", 32'(cu_state), 32'd2);
        sw_reset = 1'b1;
        @(negedge clk);
        sw_reset = 1'b0;
        model_reset();
        chk("R8 sw_reset status", 32'(status_word), 32'h0010);
        run_decode(16'h0000);

        // R11: burst of three requests gives three decodes
        base = ls_total;
        for (int i = 0; i < 3; i++) begin attn = 1'b1; scb_cmd = 16'h0; @(negedge clk); end
        attn = 1'b0;
        repeat (20) @(negedge clk);
        chk("R11 three queued decodes", 32'(ls_total - base), 32'd3);

        // R11: burst of six saturates the counter, one request lost
        base = ls_total;
        for (int i = 0; i < 6; i++) begin attn = 1'b1; @(negedge clk); end
        attn = 1'b0;
        repeat (30) @(negedge clk);
        chk("R11 saturating queue", 32'(ls_total - base), 32'd5);

        // R8 R11: sw_reset flushes pending requests
        base = ls_total;
        attn = 1'b1; @(negedge clk);
        attn = 1'b1; @(negedge clk);
        attn = 1'b0; sw_reset = 1'b1; @(negedge clk);
        sw_reset = 1'b0;
        repeat (20) @(negedge clk);
        chk("R8 R11 flush drops pending", 32'(ls_total - base), 32'd1);
        chk("R8 state after flush", 32'(status_word), 32'h0010);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule